// File: doc/BRIEF.md
# Prefix Frame Swapper

This block turns the real addresses issued by one processor of a shared-memory multiprocessor into absolute addresses, which are the addresses that actually reach main storage. Each processor keeps its own prefix register. The register names a 4 KB frame of main storage that serves as the processor's private copy of low storage.

A reference into real frame 0 is steered to the prefix frame. A reference into the frame that the prefix names is steered to absolute frame 0. Any other address is passed on unchanged. The mapping is a swap of two frames, not a relocation by an offset. The frame number is wider than the classic 12 bits, so the design also covers the extended real address range.

Software loads the prefix through a load strobe. A load applies to requests that arrive on the next cycle or later. Each request with valid set produces one registered result, one cycle later.

Top module: `prefix_swapper`

## Requirements
- R1: Reset holds the prefix frame at 0 and drives `abs_valid` and `abs_addr` to 0, so a request made after reset and before any load passes through unchanged.
- R2: A valid request whose frame field (bits ADDR_W-1..12) is 0 yields an absolute address whose frame field equals the current prefix frame.
- R3: A valid request whose frame field equals the current prefix frame yields an absolute address whose frame field is 0.
- R4: A valid request whose frame field is neither 0 nor the prefix frame yields an absolute address equal to the request address.
- R5: When the prefix frame is 0, every request address passes through unchanged.
- R6: Bits 11..0 of `pfx_value` are ignored, so the prefix always names a 4 KB-aligned frame.
- R7: `abs_valid` is high in exactly the cycle after each cycle in which `req_valid` is high.
- R8: A prefix load takes effect for requests in later cycles. A request in the same cycle as the load uses the old prefix. Without a load, the prefix is kept.
- R9: `abs_addr` holds its value in cycles that follow a cycle without a valid request.
- R10: Bits 11..0 of the absolute address always equal bits 11..0 of the request address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request address is valid this cycle |
| req_addr | input | ADDR_W | Real address to translate |
| pfx_load | input | 1 | Load `pfx_value` into the prefix register |
| pfx_value | input | ADDR_W | New prefix; only the frame bits are kept |
| abs_valid | output | 1 | Registered result is valid |
| abs_addr | output | ADDR_W | Registered absolute address |

## Verification
The hardest case to reach is a request that arrives in the same cycle as a prefix load. In that cycle the old prefix and the new prefix are both visible at the ports, and the result must follow the old one. The bench drives the load and a frame-0 request on the same clock edge, then repeats the request alone. The two results therefore differ only in which prefix they follow. The bench also loads prefixes with nonzero low bits, the highest frame, and frame 0, so that both swap conditions, and the case where they coincide, are reached.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

    localparam int PFX_ADDR_W_DEF = 26;
    localparam int PFX_OFF_W      = 12;

    typedef enum logic [1:0] {
        SWAP_PASS      = 2'd0,
        SWAP_TO_PREFIX = 2'd1,
        SWAP_TO_ZERO   = 2'd2
    } swap_kind_e;

    // Decide the redirection from the two frame comparisons.
    // Both true only when the prefix is frame 0: identity.
    function automatic swap_kind_e pick_swap(input logic is_zero, input logic is_prefix);
        if (is_zero && is_prefix) return SWAP_PASS;
        else if (is_zero)         return SWAP_TO_PREFIX;
        else if (is_prefix)       return SWAP_TO_ZERO;
        else                      return SWAP_PASS;
    endfunction

endpackage

// File: rtl/pfx_prefix_reg.sv
module pfx_prefix_reg #(
    parameter int ADDR_W = pfx_pkg::PFX_ADDR_W_DEF,
    parameter int OFF_W  = pfx_pkg::PFX_OFF_W,
    localparam int FRAME_W = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] value,
    output logic [FRAME_W-1:0] frame
);

    always_ff @(posedge clk) begin
        if (rst)       frame <= '0;
        else if (load) frame <= value[ADDR_W-1:OFF_W];
    end

    // R1
    reset_frame_chk: assert property (@(posedge clk) rst |=> frame == '0);

    // R8
    frame_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(frame));

endmodule

// File: rtl/pfx_swap_core.sv
module pfx_swap_core #(
    parameter int ADDR_W = pfx_pkg::PFX_ADDR_W_DEF,
    parameter int OFF_W  = pfx_pkg::PFX_OFF_W,
    localparam int FRAME_W = ADDR_W - OFF_W
) (
    input  logic [ADDR_W-1:0]  addr_in,
    input  logic [FRAME_W-1:0] pfx_frame,
    output logic [ADDR_W-1:0]  addr_out
);
    import pfx_pkg::*;

    logic [FRAME_W-1:0] in_frame;
    logic [FRAME_W-1:0] out_frame;
    swap_kind_e         kind;

    assign in_frame = addr_in[ADDR_W-1:OFF_W];

    always_comb begin
        kind = pick_swap(in_frame == '0, in_frame == pfx_frame);
        case (kind)
            SWAP_TO_PREFIX: out_frame = pfx_frame;
            SWAP_TO_ZERO:   out_frame = '0;
            default:        out_frame = in_frame;
        endcase
    end

    assign addr_out = {out_frame, addr_in[OFF_W-1:0]};

endmodule

// File: rtl/pfx_out_stage.sv
module pfx_out_stage #(
    parameter int ADDR_W = pfx_pkg::PFX_ADDR_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_addr <= in_addr;
        end
    end

    // R7
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R7
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_addr));

endmodule

// File: rtl/prefix_swapper.sv
module prefix_swapper #(
    parameter int ADDR_W = pfx_pkg::PFX_ADDR_W_DEF,
    localparam int OFF_W   = pfx_pkg::PFX_OFF_W,
    localparam int FRAME_W = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              pfx_load,
    input  logic [ADDR_W-1:0] pfx_value,
    output logic              abs_valid,
    output logic [ADDR_W-1:0] abs_addr
);

    logic [FRAME_W-1:0] pfx_frame;
    logic [ADDR_W-1:0]  swapped;
    logic [FRAME_W-1:0] req_frame;

    assign req_frame = req_addr[ADDR_W-1:OFF_W];

    pfx_prefix_reg #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_preg (
        .clk   (clk),
        .rst   (rst),
        .load  (pfx_load),
        .value (pfx_value),
        .frame (pfx_frame)
    );

    pfx_swap_core #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_core (
        .addr_in   (req_addr),
        .pfx_frame (pfx_frame),
        .addr_out  (swapped)
    );

    pfx_out_stage #(.ADDR_W(ADDR_W)) u_ostage (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (req_valid),
        .in_addr   (swapped),
        .out_valid (abs_valid),
        .out_addr  (abs_addr)
    );

    // R2
    zero_to_prefix_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_frame == '0) |=>
            abs_addr[ADDR_W-1:OFF_W] == $past(pfx_frame));

    // R3
    prefix_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_frame == pfx_frame) |=> abs_addr[ADDR_W-1:OFF_W] == '0);

    // R4
    other_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_frame != '0 && req_frame != pfx_frame) |=>
            abs_addr == $past(req_addr));

    // R10
    offset_keep_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> abs_addr[OFF_W-1:0] == $past(req_addr[OFF_W-1:0]));

endmodule

// File: tb/prefix_swapper_bench.sv
module prefix_swapper_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 26;
    localparam int WATCHDOG_CYCLES = 5000;

    typedef struct packed {
        logic [AW-1:0] pfx;
        logic [AW-1:0] addr;
        logic [AW-1:0] exp;
        logic [7:0]    req;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{26'h0005000, 26'h0000ABC, 26'h0005ABC, 8'd2},  // R2 frame 0 to prefix
        '{26'h0005000, 26'h0005123, 26'h0000123, 8'd3},  // R3 prefix to frame 0
        '{26'h0005000, 26'h0007FFF, 26'h0007FFF, 8'd4},  // R4 other frame
        '{26'h3FFF000, 26'h0000001, 26'h3FFF001, 8'd2},  // R2 top frame
        '{26'h3FFF000, 26'h3FFFFFF, 26'h0000FFF, 8'd3},  // R3 top frame
        '{26'h0000000, 26'h0000456, 26'h0000456, 8'd5},  // R5 zero prefix
        '{26'h0012FFF, 26'h0000010, 26'h0012010, 8'd6},  // R6 low bits dropped
        '{26'h0012FFF, 26'h0012020, 26'h0000020, 8'd6},  // R6 low bits dropped
        '{26'h0001000, 26'h0002345, 26'h0002345, 8'd4},  // R4 neighbour frame
        '{26'h0001000, 26'h0001000, 26'h0000000, 8'd3}   // R3 offset 0
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          pfx_load = 1'b0;
    logic [AW-1:0] pfx_value = '0;
    logic          abs_valid;
    logic [AW-1:0] abs_addr;

    int checks = 0;
    int errors = 0;

    prefix_swapper #(.ADDR_W(AW)) u_prefix_swapper (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .pfx_load  (pfx_load),
        .pfx_value (pfx_value),
        .abs_valid (abs_valid),
        .abs_addr  (abs_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load_pfx(input logic [AW-1:0] v);
        @(negedge clk);
        pfx_load  = 1'b1;
        pfx_value = v;
        @(negedge clk);
        pfx_load  = 1'b0;
    endtask

    // Drive one request; the result is registered at the next rising edge
    // and sampled at the following falling edge.
    task automatic request(input logic [AW-1:0] a);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 abs_valid after reset", {25'd0, abs_valid}, '0);
        check("R1 abs_addr after reset", abs_addr, '0);
        rst = 1'b0;

        // R1 prefix is 0 after reset: identity
        request(26'h0000777);
        check("R1 pass before load", abs_addr, 26'h0000777);
        check("R7 valid after request", {25'd0, abs_valid}, 26'd1);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            load_pfx(VECS[i].pfx);
            request(VECS[i].addr);
            checks++;
            if (abs_addr !== VECS[i].exp || abs_valid !== 1'b1) begin
                errors++;
                $display("FAIL R%0d vec %0d: actual=%h expected=%h", VECS[i].req, i,
                         abs_addr, VECS[i].exp);
            end
            // R10 offset unchanged
            check("R10 offset", {14'd0, abs_addr[11:0]}, {14'd0, VECS[i].addr[11:0]});
        end

        // R9 hold and R7 idle: after an idle cycle nothing changes
        load_pfx(26'h0005000);
        request(26'h0000ABC);
        check("R2 setup", abs_addr, 26'h0005ABC);
        @(negedge clk);
        check("R7 valid low when idle", {25'd0, abs_valid}, '0);
        check("R9 addr held", abs_addr, 26'h0005ABC);
        req_addr = 26'h0000FFF;
        @(negedge clk);
        check("R9 addr ignores invalid input", abs_addr, 26'h0005ABC);

        // R8 load and request in the same cycle: old prefix applies
        @(negedge clk);
        pfx_load  = 1'b1;
        pfx_value = 26'h0009000;
        req_valid = 1'b1;
        req_addr  = 26'h0000100;
        @(negedge clk);
        pfx_load  = 1'b0;
        req_valid = 1'b0;
        check("R8 same-cycle uses old prefix", abs_addr, 26'h0005100);
        request(26'h0000100);
        check("R8 next request uses new prefix", abs_addr, 26'h0009100);
        request(26'h0005222);
        check("R8 old prefix frame no longer swapped", abs_addr, 26'h0005222);

        // R8 prefix kept without load (pfx_value changes alone)
        @(negedge clk);
        pfx_value = 26'h0003000;
        request(26'h0000200);
        check("R8 value without load ignored", abs_addr, 26'h0009200);

        // R7 back-to-back requests
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = 26'h0009001;
        @(negedge clk);
        check("R7 first of pair valid", {25'd0, abs_valid}, 26'd1);
        check("R3 first of pair", abs_addr, 26'h0000001);
        req_addr = 26'h0000002;
        @(negedge clk);
        req_valid = 1'b0;
        check("R7 second of pair valid", {25'd0, abs_valid}, 26'd1);
        check("R2 second of pair", abs_addr, 26'h0009002);
        @(negedge clk);
        check("R7 valid drops", {25'd0, abs_valid}, '0);

        // R1 reset mid-run clears prefix
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 abs_addr cleared", abs_addr, '0);
        request(26'h0009300);
        check("R1 prefix cleared by reset", abs_addr, 26'h0009300);

        finish_run();
    end

endmodule